// File: doc/BRIEF.md
# Four-Channel Complementary PWM Generator with Dead Time and Trigger Pulses

The block drives four half-bridge channels from one free-running counter. Each channel has a high-side output and a low-side output. A per-channel duty value sets how long the high side conducts in each period. Two separate dead-time settings hold off the turn-on of each side after the other side turns off. One alignment setting applies to all channels. It places the on-window at the start of the period, at its end, or centred in it. The counter limit sets the period, which lasts limit + 1 clocks in every alignment.

Alongside the gate outputs the block produces five trigger pulses for converters and interrupt logic:
- one at the start of each period;
- one at the period midpoint;
- two at programmable counter positions;
- the OR of those two.

Every trigger lasts a programmable number of clocks. Separate polarity bits invert the high-side group, the low-side group and the trigger group. Settings are written through a single-cycle write port. The limit, alignment, duty and compare values are staged and take effect together at the next period boundary.

Top module: `pwm_quad`

## Requirements
- R1: The counter runs 0..limit and wraps, so a period lasts limit+1 clocks; the limit (address 0) is 12 bits wide.
- R2: With alignment code 0 (left, address 1), a channel's on-window covers counts 0 .. d-1, where d is the effective duty (address 8 + channel, 13 bits).
- R3: With alignment code 2 (right), the on-window covers the last d counts of the period.
- R4: With alignment code 1 (centred), the on-window starts at count (P-d)/2, rounded down, and lasts d counts, with P = limit+1; code 3 behaves as left.
- R5: A duty of 0 keeps the high side off for the whole period. A duty of P or more keeps it on for the whole period, because the effective duty is min(duty, P).
- R6: Gate outputs follow the on-window one clock after the counter. The high side turns on only after the window has been on for the high dead time (address 2) in consecutive clocks. The low side turns on only after the window has been off for the low dead time (address 3) in consecutive clocks.
- R7: When a dead time exceeds the time the window stays in a state, the affected side stays off for that whole interval; high and low are never active together.
- R8: The start trigger begins one clock after count 0. The midpoint trigger begins one clock after count P/2, rounded down.
- R9: Trigger A and trigger B begin one clock after the counter equals compare A (address 6) or compare B (address 7). The combined trigger is the OR of A and B.
- R10: Each trigger stays active for exactly the pulse length (address 4) clocks, and a new event restarts it. A length of 0 produces no pulse.
- R11: Polarity bits (address 5) invert outputs: bit 0 the high sides, bit 1 the low sides, bit 2 all triggers.
- R12: Writes to limit, alignment, duty and compares take effect only at the first period start after the write; dead times, pulse length and polarity apply on the next clock.
- R13: After reset all high sides are off, all low sides are on, and all triggers are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 16 | Register write data |
| pwmHigh | output | 4 | High-side gate outputs, one per channel |
| pwmLow | output | 4 | Low-side gate outputs, one per channel |
| trigZero | output | 1 | Period-start trigger |
| trigCenter | output | 1 | Period-midpoint trigger |
| trigA | output | 1 | Compare A trigger |
| trigB | output | 1 | Compare B trigger |
| trigAB | output | 1 | OR of compare triggers |

## Verification
The hardest case is a duty write that lands in the middle of a period. Here the staged value must stay invisible until the wrap. The bench watches its own model of the counter and waits for a chosen count before issuing the write. It then samples the output both later in the same period and at the same count one period later. A second hard case is a dead time longer than the on-window. The bench shrinks one channel to a two-clock right-aligned window, sets a five-clock high dead time, and confirms that the high side never turns on across a full period. A reference model compares every output on every clock throughout, including after each change of alignment mode.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  typedef enum logic [1:0] {
    ALIGN_LEFT   = 2'd0,
    ALIGN_CENTER = 2'd1,
    ALIGN_RIGHT  = 2'd2
  } alignMode_e;

  typedef struct packed {
    logic cycleStart;
    logic centerHit;
    logic hitA;
    logic hitB;
  } trigStrobe_t;

  localparam int ADDR_LIMIT = 0;
  localparam int ADDR_ALIGN = 1;
  localparam int ADDR_DTH   = 2;
  localparam int ADDR_DTL   = 3;
  localparam int ADDR_PLEN  = 4;
  localparam int ADDR_POL   = 5;
  localparam int ADDR_CMPA  = 6;
  localparam int ADDR_CMPB  = 7;
  localparam int ADDR_DUTY0 = 8;

endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int CH  = 4,
  parameter int CW  = 12,
  parameter int DTW = 8,
  parameter int PLW = 8,
  parameter int AW  = 4,
  parameter int DW  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [AW-1:0]        wrAddr,
  input  logic [DW-1:0]        wrData,
  output logic [CW-1:0]        cnt,
  output logic [CW:0]          period,
  output alignMode_e           modeAct,
  output logic [CH-1:0][CW:0]  dutyAct,
  output logic [DTW-1:0]       dtHigh,
  output logic [DTW-1:0]       dtLow,
  output logic [PLW-1:0]       pulseLen,
  output logic                 polHigh,
  output logic                 polLow,
  output logic                 polTrig,
  output trigStrobe_t          strobe
);

  logic [CW-1:0]       maxStg, maxAct, cmpAStg, cmpBStg, cmpAAct, cmpBAct;
  logic [1:0]          modeStg;
  logic [CH-1:0][CW:0] dutyStg;
  logic                wrap;

  assign wrap   = (cnt == maxAct);
  assign period = {1'b0, maxAct} + 1'b1;

  // staging and immediate registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxStg   <= '0;
      modeStg  <= '0;
      cmpAStg  <= '0;
      cmpBStg  <= '0;
      dutyStg  <= '0;
      dtHigh   <= '0;
      dtLow    <= '0;
      pulseLen <= '0;
      polHigh  <= 1'b0;
      polLow   <= 1'b0;
      polTrig  <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        AW'(ADDR_LIMIT): maxStg   <= wrData[CW-1:0];
        AW'(ADDR_ALIGN): modeStg  <= wrData[1:0];
        AW'(ADDR_DTH):   dtHigh   <= wrData[DTW-1:0];
        AW'(ADDR_DTL):   dtLow    <= wrData[DTW-1:0];
        AW'(ADDR_PLEN):  pulseLen <= wrData[PLW-1:0];
        AW'(ADDR_POL): begin
          polHigh <= wrData[0];
          polLow  <= wrData[1];
          polTrig <= wrData[2];
        end
        AW'(ADDR_CMPA):  cmpAStg  <= wrData[CW-1:0];
        AW'(ADDR_CMPB):  cmpBStg  <= wrData[CW-1:0];
        default: ;
      endcase
      for (int i = 0; i < CH; i++)
        if (wrAddr == AW'(ADDR_DUTY0 + i)) dutyStg[i] <= wrData[CW:0];
    end
  end

  // shared counter and period-boundary shadow load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      maxAct  <= '0;
      modeAct <= ALIGN_LEFT;
      cmpAAct <= '0;
      cmpBAct <= '0;
      dutyAct <= '0;
    end else if (wrap) begin
      cnt     <= '0;
      maxAct  <= maxStg;
      modeAct <= alignMode_e'(modeStg);
      cmpAAct <= cmpAStg;
      cmpBAct <= cmpBStg;
      dutyAct <= dutyStg;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign strobe.cycleStart = (cnt == '0);
  assign strobe.centerHit  = ({1'b0, cnt} == (period >> 1));
  assign strobe.hitA       = (cnt == cmpAAct);
  assign strobe.hitB       = (cnt == cmpBAct);

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= maxAct);

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == maxAct) |=> (cnt == '0));

  a_r12_hold_mid_period: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != maxAct) |=> ($stable(maxAct) && $stable(dutyAct) && $stable(cmpAAct)));

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
#(
  parameter int CW  = 12,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [CW-1:0]  cnt,
  input  logic [CW:0]    period,
  input  alignMode_e     modeAct,
  input  logic [CW:0]    duty,
  input  logic [DTW-1:0] dtHigh,
  input  logic [DTW-1:0] dtLow,
  output logic           hiAct,
  output logic           loAct
);

  localparam logic [DTW-1:0] STEADY_MAX = '1;

  logic [CW:0]    dEff, winLo, winHi, cntExt;
  logic           rawOn, rawPrev;
  logic [DTW-1:0] steady;

  assign cntExt = {1'b0, cnt};
  assign dEff   = (duty > period) ? period : duty;

  always_comb begin
    case (modeAct)
      ALIGN_RIGHT: begin
        winLo = period - dEff;
        winHi = period;
      end
      ALIGN_CENTER: begin
        winLo = (period - dEff) >> 1;
        winHi = ((period - dEff) >> 1) + dEff;
      end
      default: begin
        winLo = '0;
        winHi = dEff;
      end
    endcase
  end

  assign rawOn = (cntExt >= winLo) && (cntExt < winHi);

  // dead time: count clocks the window has kept its state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawPrev <= 1'b0;
      steady  <= '0;
    end else begin
      rawPrev <= rawOn;
      if (rawOn != rawPrev)        steady <= '0;
      else if (steady != STEADY_MAX) steady <= steady + 1'b1;
    end
  end

  assign hiAct = rawPrev && (steady >= dtHigh);
  assign loAct = !rawPrev && (steady >= dtLow);

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(hiAct && loAct));

endmodule

// File: rtl/pwm_quad_dp.sv
module pwm_quad_dp
  import pwm_quad_pkg::*;
#(
  parameter int CH  = 4,
  parameter int CW  = 12,
  parameter int DTW = 8,
  parameter int PLW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CW-1:0]       cnt,
  input  logic [CW:0]         period,
  input  alignMode_e          modeAct,
  input  logic [CH-1:0][CW:0] dutyAct,
  input  logic [DTW-1:0]      dtHigh,
  input  logic [DTW-1:0]      dtLow,
  input  logic [PLW-1:0]      pulseLen,
  input  logic                polHigh,
  input  logic                polLow,
  input  logic                polTrig,
  input  trigStrobe_t         strobe,
  output logic [CH-1:0]       pwmHigh,
  output logic [CH-1:0]       pwmLow,
  output logic                trigZero,
  output logic                trigCenter,
  output logic                trigA,
  output logic                trigB,
  output logic                trigAB
);

  localparam int NTRIG = 4;

  logic [CH-1:0]    hiVec, loVec;
  logic [NTRIG-1:0] trigEv, trigAct;

  for (genvar g = 0; g < CH; g++) begin : gChan
    pwm_quad_chan #(.CW(CW), .DTW(DTW)) uChan (
      .clk     (clk),
      .rstN    (rstN),
      .cnt     (cnt),
      .period  (period),
      .modeAct (modeAct),
      .duty    (dutyAct[g]),
      .dtHigh  (dtHigh),
      .dtLow   (dtLow),
      .hiAct   (hiVec[g]),
      .loAct   (loVec[g])
    );
  end

  assign trigEv = {strobe.hitB, strobe.hitA, strobe.centerHit, strobe.cycleStart};

  for (genvar k = 0; k < NTRIG; k++) begin : gTrig
    logic [PLW-1:0] remCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              remCnt <= '0;
      else if (trigEv[k])     remCnt <= pulseLen;
      else if (remCnt != '0)  remCnt <= remCnt - 1'b1;
    end
    assign trigAct[k] = (remCnt != '0);
  end

  assign pwmHigh    = hiVec ^ {CH{polHigh}};
  assign pwmLow     = loVec ^ {CH{polLow}};
  assign trigZero   = trigAct[0] ^ polTrig;
  assign trigCenter = trigAct[1] ^ polTrig;
  assign trigA      = trigAct[2] ^ polTrig;
  assign trigB      = trigAct[3] ^ polTrig;
  assign trigAB     = (trigAct[2] | trigAct[3]) ^ polTrig;

  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cycleStart && pulseLen != '0) |=> trigAct[0]);

  a_r9_compare_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hitA && pulseLen != '0) |=> trigAct[2]);

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int CH  = 4,
  parameter int CW  = 12,
  parameter int DTW = 8,
  parameter int PLW = 8,
  parameter int AW  = 4,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic [CH-1:0] pwmHigh,
  output logic [CH-1:0] pwmLow,
  output logic          trigZero,
  output logic          trigCenter,
  output logic          trigA,
  output logic          trigB,
  output logic          trigAB
);

  logic [CW-1:0]       cnt;
  logic [CW:0]         period;
  alignMode_e          modeAct;
  logic [CH-1:0][CW:0] dutyAct;
  logic [DTW-1:0]      dtHigh, dtLow;
  logic [PLW-1:0]      pulseLen;
  logic                polHigh, polLow, polTrig;
  trigStrobe_t         strobe;

  pwm_quad_ctrl #(.CH(CH), .CW(CW), .DTW(DTW), .PLW(PLW), .AW(AW), .DW(DW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .cnt      (cnt),
    .period   (period),
    .modeAct  (modeAct),
    .dutyAct  (dutyAct),
    .dtHigh   (dtHigh),
    .dtLow    (dtLow),
    .pulseLen (pulseLen),
    .polHigh  (polHigh),
    .polLow   (polLow),
    .polTrig  (polTrig),
    .strobe   (strobe)
  );

  pwm_quad_dp #(.CH(CH), .CW(CW), .DTW(DTW), .PLW(PLW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .cnt        (cnt),
    .period     (period),
    .modeAct    (modeAct),
    .dutyAct    (dutyAct),
    .dtHigh     (dtHigh),
    .dtLow      (dtLow),
    .pulseLen   (pulseLen),
    .polHigh    (polHigh),
    .polLow     (polLow),
    .polTrig    (polTrig),
    .strobe     (strobe),
    .pwmHigh    (pwmHigh),
    .pwmLow     (pwmLow),
    .trigZero   (trigZero),
    .trigCenter (trigCenter),
    .trigA      (trigA),
    .trigB      (trigB),
    .trigAB     (trigAB)
  );

endmodule

// File: tb/pwm_quad_test.sv
module pwm_quad_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  pwmHigh, pwmLow;
  logic        trigZero, trigCenter, trigA, trigB, trigAB;

  always #5 clk = ~clk;

  pwm_quad uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmHigh(pwmHigh), .pwmLow(pwmLow), .trigZero(trigZero),
    .trigCenter(trigCenter), .trigA(trigA), .trigB(trigB), .trigAB(trigAB)
  );

  int nTests = 0, nFail = 0;
  bit done = 0, armed = 0;

  // behavioural reference state
  int sMax, sMode, sCmpA, sCmpB, sDuty[4];
  int mMax, mMode, mCmpA, mCmpB, mDuty[4];
  int mDtH, mDtL, mPlen, mPol, mCnt;
  bit mRaw[4];
  int mStab[4], mRem[4];

  task automatic chk(bit ok, string tag, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit winOn(int c, int d, int mx, int md);
    int p, de, s;
    p  = mx + 1;
    de = (d > p) ? p : d;
    if (md == 2) return c >= p - de;
    if (md == 1) begin
      s = (p - de) / 2;
      return (c >= s) && (c < s + de);
    end
    return c < de;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      sMax = 0; sMode = 0; sCmpA = 0; sCmpB = 0;
      mMax = 0; mMode = 0; mCmpA = 0; mCmpB = 0;
      mDtH = 0; mDtL = 0; mPlen = 0; mPol = 0; mCnt = 0;
      for (int i = 0; i < 4; i++) begin
        sDuty[i] = 0; mDuty[i] = 0; mRaw[i] = 0; mStab[i] = 0; mRem[i] = 0;
      end
    end else begin
      bit ev[4];
      for (int i = 0; i < 4; i++) begin
        bit nr;
        nr = winOn(mCnt, mDuty[i], mMax, mMode);
        if (nr != mRaw[i]) mStab[i] = 0;
        else if (mStab[i] < 255) mStab[i]++;
        mRaw[i] = nr;
      end
      ev[0] = (mCnt == 0);
      ev[1] = (mCnt == (mMax + 1) / 2);
      ev[2] = (mCnt == mCmpA);
      ev[3] = (mCnt == mCmpB);
      for (int k = 0; k < 4; k++)
        if (ev[k]) mRem[k] = mPlen;
        else if (mRem[k] > 0) mRem[k]--;
      if (mCnt == mMax) begin
        mCnt = 0; mMax = sMax; mMode = sMode; mCmpA = sCmpA; mCmpB = sCmpB;
        for (int i = 0; i < 4; i++) mDuty[i] = sDuty[i];
      end else mCnt++;
      if (wrEn) begin
        case (int'(wrAddr))
          0: sMax  = wrData & 16'h0FFF;
          1: sMode = wrData & 16'h0003;
          2: mDtH  = wrData & 16'h00FF;
          3: mDtL  = wrData & 16'h00FF;
          4: mPlen = wrData & 16'h00FF;
          5: mPol  = wrData & 16'h0007;
          6: sCmpA = wrData & 16'h0FFF;
          7: sCmpB = wrData & 16'h0FFF;
          8, 9, 10, 11: sDuty[int'(wrAddr) - 8] = wrData & 16'h1FFF;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && armed) begin
      logic [3:0] eh, el, hn, ln;
      logic [4:0] et, at;
      string tagH;
      for (int i = 0; i < 4; i++) begin
        eh[i] = (mRaw[i] && mStab[i] >= mDtH) ^ mPol[0];
        el[i] = (!mRaw[i] && mStab[i] >= mDtL) ^ mPol[1];
      end
      tagH = (mMode == 1) ? "R4 centred high" : (mMode == 2) ? "R3 right high" : "R2 left high";
      chk(pwmHigh == eh, tagH, pwmHigh, eh);
      chk(pwmLow == el, "R6 low side", pwmLow, el);
      hn = pwmHigh ^ {4{mPol[0]}};
      ln = pwmLow ^ {4{mPol[1]}};
      chk((hn & ln) == 0, "R7 overlap", hn & ln, 0);
      et = {(mRem[2] > 0) || (mRem[3] > 0), mRem[3] > 0, mRem[2] > 0,
            mRem[1] > 0, mRem[0] > 0};
      et = et ^ {5{mPol[2]}};
      at = {trigAB, trigB, trigA, trigCenter, trigZero};
      chk(at[1:0] == et[1:0], "R8 start/mid trigger", at[1:0], et[1:0]);
      chk(at[4:2] == et[4:2], "R9 compare triggers", at[4:2], et[4:2]);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 16'(d);
    tick();
    wrEn = 1'b0;
  endtask

  initial begin
    int n, cntH0, cntH3;
    tick(3);
    rstN = 1'b1;
    // R13 reset state
    chk(pwmHigh == 4'h0, "R13 high after reset", pwmHigh, 0);
    chk(pwmLow == 4'hF, "R13 low after reset", pwmLow, 4'hF);
    chk({trigZero, trigCenter, trigA, trigB, trigAB} == 5'b0, "R13 triggers after reset",
        {trigZero, trigCenter, trigA, trigB, trigAB}, 0);
    armed = 1;

    wr(0, 9); wr(1, 0); wr(4, 2); wr(6, 3); wr(7, 7);
    wr(8, 0); wr(9, 3); wr(10, 10); wr(11, 12);
    tick(25);

    // R1 period length from start-trigger spacing
    for (int k = 0; k < 50 && trigZero; k++) tick();
    for (int k = 0; k < 50 && !trigZero; k++) tick();
    n = 0;
    for (int k = 0; k < 50 && trigZero; k++) begin tick(); n++; end
    for (int k = 0; k < 50 && !trigZero; k++) begin tick(); n++; end
    chk(n == 10, "R1 period", n, 10);

    // R10 pulse width of trigger A
    for (int k = 0; k < 50 && trigA; k++) tick();
    for (int k = 0; k < 50 && !trigA; k++) tick();
    n = 0;
    for (int k = 0; k < 50 && trigA; k++) begin tick(); n++; end
    chk(n == 2, "R10 pulse width", n, 2);

    // R5 duty extremes
    cntH0 = 0; cntH3 = 0;
    for (int k = 0; k < 10; k++) begin
      cntH0 += pwmHigh[0]; cntH3 += pwmHigh[3]; tick();
    end
    chk(cntH0 == 0, "R5 zero duty", cntH0, 0);
    chk(cntH3 == 10, "R5 over-full duty", cntH3, 10);

    // R4 centred, R3 right
    wr(1, 1); wr(8, 4); wr(9, 5); tick(30);
    wr(1, 2); tick(30);
    wr(1, 3); tick(20);
    wr(1, 2);

    // R6 dead times
    wr(2, 2); wr(3, 3); tick(30);

    // R7 dead time longer than on-window
    wr(9, 2); wr(2, 5); tick(25);
    n = 0;
    for (int k = 0; k < 10; k++) begin n += pwmHigh[1]; tick(); end
    chk(n == 0, "R7 high suppressed", n, 0);

    // R12 mid-period duty write
    wr(2, 0); wr(3, 0); wr(1, 0); wr(8, 0); wr(10, 5); tick(25);
    for (int k = 0; k < 50 && mCnt != 1; k++) tick();
    wr(10, 0);
    for (int k = 0; k < 50 && mCnt != 3; k++) tick();
    chk(pwmHigh[2] == 1'b1, "R12 old duty held", pwmHigh[2], 1);
    tick();
    for (int k = 0; k < 50 && mCnt != 3; k++) tick();
    chk(pwmHigh[2] == 1'b0, "R12 new duty applied", pwmHigh[2], 0);

    // R11 polarity
    wr(5, 7); tick(25);
    chk(pwmHigh[0] == 1'b1, "R11 inverted idle high", pwmHigh[0], 1);
    chk(pwmLow[0] == 1'b0, "R11 inverted active low", pwmLow[0], 0);

    // R10 zero length gives no pulses
    wr(5, 0); wr(4, 0); tick(5);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      n += trigZero + trigCenter + trigA + trigB + trigAB; tick();
    end
    chk(n == 0, "R10 zero length silent", n, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule